// File: doc/BRIEF.md
# Hardware RTS/CTS Flow Controller

This block performs automatic hardware handshaking for a serial port with a receive FIFO. On the receive side it watches the FIFO occupancy and drives an active-low request-to-send line with hysteresis. The line is released (driven high) when the occupancy climbs to an upper mark. It is driven low again only once the FIFO has drained to a lower mark. Separately from these two marks, a receive-data interrupt goes high while the occupancy is at or above a trigger level. Reception is not stopped by the interrupt.

On the transmit side, an active-low clear-to-send input passes through a synchronizer and gates a transmit-permit output. The permit is updated only at character boundaries, that is on cycles where the serializer reports idle. Because of this, a stop request never cuts a character that is already being shifted out. The receive and transmit halves each have their own automatic-mode enable. With automatic RTS off, the RTS pin follows a software bit. The FIFO and the serializer sit outside this block.

Top module: `rts_cts_flow`

## Requirements
- R1: While reset is applied, and until the first clock edge after it, rtsN is 1, txPermit is 1 and rxIrq is 0. The synchronizer resets to "CTS asserted".
- R2: One clock edge after a cycle where fillLevel >= trigLevel, rxIrq is 1. One edge after a cycle where fillLevel < trigLevel, rxIrq is 0.
- R3: With autoRtsEn=1 and rtsLow < rtsHigh, a cycle with fillLevel >= rtsHigh makes rtsN 1 after the next edge.
- R4: With autoRtsEn=1 and rtsLow < rtsHigh, once rtsN is 1 it stays 1 while fillLevel > rtsLow. It returns to 0 at the edge after fillLevel <= rtsLow.
- R5: With autoRtsEn=1 and rtsLow >= rtsHigh, a stopped RTS resumes only when fillLevel < rtsHigh, which means below both marks. Reaching rtsHigh still stops it.
- R6: With autoRtsEn=0, rtsN equals the inverse of swRts one edge later, whatever the fill. The hysteresis state keeps tracking the fill, so re-enabling automatic mode with the fill above rtsHigh gives rtsN=1.
- R7: A change on ctsN reaches txPermit at the third rising edge after the change, provided txIdle=1 and autoCtsEn=1. It has no effect at the first or second edge.
- R8: txPermit changes only at edges where txIdle=1. While txIdle=0 it holds its value, whatever ctsN does.
- R9: With autoCtsEn=0, txPermit becomes 1 at the next edge with txIdle=1, even if ctsN=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| fillLevel | input | CNT_W | Current receive FIFO occupancy |
| trigLevel | input | CNT_W | Occupancy at which the receive interrupt is raised |
| rtsHigh | input | CNT_W | Upper mark: RTS is released at or above it |
| rtsLow | input | CNT_W | Lower mark: RTS is reasserted at or below it |
| autoRtsEn | input | 1 | 1 = RTS driven by the hysteresis logic |
| swRts | input | 1 | Software RTS request (1 = assert, pin low) when automatic RTS is off |
| autoCtsEn | input | 1 | 1 = transmission gated by CTS |
| ctsN | input | 1 | Active-low clear-to-send from the remote side, asynchronous |
| txIdle | input | 1 | Serializer is idle and about to load the next byte |
| rtsN | output | 1 | Active-low request-to-send to the remote side |
| txPermit | output | 1 | 1 = the serializer may start the next character |
| rxIrq | output | 1 | Receive-data-ready interrupt |

## Verification
The hardest state to reach from the ports is a CTS deassertion that arrives while a character is in flight. The synchronizer has by then carried it through, but the boundary that applies it has not yet come. The stimulus holds txIdle low, raises ctsN and waits well beyond the synchronizer delay before reopening the boundary. This shows that the permit held and then flipped at exactly the idle edge. The reversed-threshold case is reached by programming the lower mark above the upper one. The fill is then walked into the band between them after a stop, where a plain "at or below the lower mark" rule would wrongly resume.

// File: rtl/flowctl_pkg.sv
package flowctl_pkg;
  // Comparator and synchronizer results passed from datapath to control
  typedef struct packed {
    logic atHigh;
    logic canResume;
    logic ctsOn;
  } flowCmp_t;

  // Strobes passed from control back to datapath
  typedef struct packed {
    logic haltNext;
    logic permitLoad;
    logic permitVal;
  } flowStb_t;

  typedef enum logic {RX_RUN = 1'b0, RX_STOP = 1'b1} rxState_t;
endpackage

// File: rtl/flowctl_dp.sv
module flowctl_dp
  import flowctl_pkg::*;
#(
  parameter int CNT_W       = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] fillLevel,
  input  logic [CNT_W-1:0] trigLevel,
  input  logic [CNT_W-1:0] rtsHigh,
  input  logic [CNT_W-1:0] rtsLow,
  input  logic             autoRtsEn,
  input  logic             swRts,
  input  logic             ctsN,
  input  flowStb_t         stb,
  output flowCmp_t         cmp,
  output logic             rtsN,
  output logic             txPermit,
  output logic             rxIrq
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] ctsSync;
  logic          orderOk;

  // Synchronizer chain for the asynchronous CTS input
  genvar g;
  generate
    for (g = 0; g <= LAST; g++) begin : gSync
      if (g == 0) begin : gFirst
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) ctsSync[g] <= 1'b0;
          else       ctsSync[g] <= ctsN;
        end
      end else begin : gRest
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) ctsSync[g] <= 1'b0;
          else       ctsSync[g] <= ctsSync[g-1];
        end
      end
    end
  endgenerate

  always_comb begin
    orderOk       = rtsLow < rtsHigh;
    cmp.atHigh    = fillLevel >= rtsHigh;
    cmp.canResume = orderOk ? (fillLevel <= rtsLow) : (fillLevel < rtsHigh);
    cmp.ctsOn     = ~ctsSync[LAST];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rtsN     <= 1'b1;
      txPermit <= 1'b1;
      rxIrq    <= 1'b0;
    end else begin
      rtsN  <= autoRtsEn ? stb.haltNext : ~swRts;
      rxIrq <= fillLevel >= trigLevel;
      if (stb.permitLoad) txPermit <= stb.permitVal;
    end
  end
endmodule

// File: rtl/flowctl_ctrl.sv
module flowctl_ctrl
  import flowctl_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  flowCmp_t cmp,
  input  logic     autoCtsEn,
  input  logic     txIdle,
  output flowStb_t stb
);
  rxState_t rxState, rxNext;

  always_comb begin
    rxNext = rxState;
    case (rxState)
      RX_RUN:  if (cmp.atHigh)    rxNext = RX_STOP;
      RX_STOP: if (cmp.canResume) rxNext = RX_RUN;
      default: rxNext = RX_STOP;
    endcase
    stb.haltNext   = (rxNext == RX_STOP);
    stb.permitLoad = txIdle;
    stb.permitVal  = ~autoCtsEn | cmp.ctsOn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rxState <= RX_STOP;
    else       rxState <= rxNext;
  end
endmodule

// File: rtl/rts_cts_flow.sv
module rts_cts_flow
  import flowctl_pkg::*;
#(
  parameter int CNT_W       = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] fillLevel,
  input  logic [CNT_W-1:0] trigLevel,
  input  logic [CNT_W-1:0] rtsHigh,
  input  logic [CNT_W-1:0] rtsLow,
  input  logic             autoRtsEn,
  input  logic             swRts,
  input  logic             autoCtsEn,
  input  logic             ctsN,
  input  logic             txIdle,
  output logic             rtsN,
  output logic             txPermit,
  output logic             rxIrq
);
  flowCmp_t cmp;
  flowStb_t stb;

  flowctl_dp #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .fillLevel(fillLevel), .trigLevel(trigLevel),
    .rtsHigh(rtsHigh), .rtsLow(rtsLow), .autoRtsEn(autoRtsEn), .swRts(swRts),
    .ctsN(ctsN), .stb(stb), .cmp(cmp), .rtsN(rtsN), .txPermit(txPermit),
    .rxIrq(rxIrq)
  );

  flowctl_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cmp(cmp), .autoCtsEn(autoCtsEn),
    .txIdle(txIdle), .stb(stb)
  );
endmodule

// File: rtl/flowctl_chk.sv
module flowctl_chk #(
  parameter int CNT_W = 6
) (
  input logic             clk,
  input logic             rstN,
  input logic [CNT_W-1:0] fillLevel,
  input logic [CNT_W-1:0] trigLevel,
  input logic [CNT_W-1:0] rtsHigh,
  input logic [CNT_W-1:0] rtsLow,
  input logic             autoRtsEn,
  input logic             swRts,
  input logic             txIdle,
  input logic             rtsN,
  input logic             txPermit,
  input logic             rxIrq
);
  assert_reset_vals_R1: assert property (@(posedge clk)
    !rstN |=> (rtsN && txPermit && !rxIrq));

  assert_irq_set_R2: assert property (@(posedge clk) disable iff (!rstN)
    (fillLevel >= trigLevel) |=> rxIrq);

  assert_rts_stop_R3: assert property (@(posedge clk) disable iff (!rstN)
    (autoRtsEn && (rtsLow < rtsHigh) && (fillLevel >= rtsHigh)) |=> rtsN);

  assert_rts_resume_R4: assert property (@(posedge clk) disable iff (!rstN)
    (autoRtsEn && (rtsLow < rtsHigh) && (fillLevel <= rtsLow)) |=> !rtsN);

  assert_sw_rts_R6: assert property (@(posedge clk) disable iff (!rstN)
    !autoRtsEn |=> (rtsN == !$past(swRts)));

  assert_boundary_only_R8: assert property (@(posedge clk) disable iff (!rstN)
    !$past(txIdle) |-> $stable(txPermit));
endmodule

bind rts_cts_flow flowctl_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .fillLevel(fillLevel), .trigLevel(trigLevel),
  .rtsHigh(rtsHigh), .rtsLow(rtsLow), .autoRtsEn(autoRtsEn), .swRts(swRts),
  .txIdle(txIdle), .rtsN(rtsN), .txPermit(txPermit), .rxIrq(rxIrq)
);

// File: tb/tb_rts_cts_flow.sv
`timescale 1ns/1ps
module tb_rts_cts_flow;
  localparam int W = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [W-1:0] fillLevel = '0, trigLevel = 6'd8, rtsHigh = 6'd24, rtsLow = 6'd10;
  logic autoRtsEn = 1'b1, swRts = 1'b0, autoCtsEn = 1'b1, ctsN = 1'b0, txIdle = 1'b1;
  logic rtsN, txPermit, rxIrq;

  int errors = 0;
  int checks = 0;
  string curReq = "R1";
  bit done = 0;

  // Reference model state
  bit mRts = 1, mPermit = 1, mIrq = 0, mHalted = 1, mS1 = 0, mS2 = 0;

  always #10 clk = ~clk;

  rts_cts_flow #(.CNT_W(W)) dut (
    .clk(clk), .rstN(rstN), .fillLevel(fillLevel), .trigLevel(trigLevel),
    .rtsHigh(rtsHigh), .rtsLow(rtsLow), .autoRtsEn(autoRtsEn), .swRts(swRts),
    .autoCtsEn(autoCtsEn), .ctsN(ctsN), .txIdle(txIdle), .rtsN(rtsN),
    .txPermit(txPermit), .rxIrq(rxIrq)
  );

  task automatic chk(input string what, input bit got, input bit exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %b expected %b", curReq, what, got, exp);
    end
  endtask

  task automatic modelEdge();
    bit valid;
    if (!rstN) begin
      mRts = 1; mPermit = 1; mIrq = 0; mHalted = 1; mS1 = 0; mS2 = 0;
    end else begin
      valid = rtsLow < rtsHigh;
      mIrq = fillLevel >= trigLevel;
      if (mHalted) begin
        if (valid ? (fillLevel <= rtsLow) : (fillLevel < rtsHigh)) mHalted = 0;
      end else if (fillLevel >= rtsHigh) mHalted = 1;
      mRts = autoRtsEn ? mHalted : !swRts;
      if (txIdle) mPermit = !autoCtsEn || !mS2;
      mS2 = mS1;
      mS1 = ctsN;
    end
  endtask

  // One clock: model updates at the edge, outputs compared at the falling edge
  task automatic step();
    @(posedge clk);
    modelEdge();
    @(negedge clk);
    chk("rtsN vs model", rtsN, mRts);
    chk("txPermit vs model", txPermit, mPermit);
    chk("rxIrq vs model", rxIrq, mIrq);
  endtask

  initial begin
    repeat (3) step();
    curReq = "R1";
    chk("rtsN in reset", rtsN, 1'b1);
    chk("txPermit in reset", txPermit, 1'b1);
    chk("rxIrq in reset", rxIrq, 1'b0);
    rstN = 1'b1;
    repeat (3) step();

    // Interrupt trigger, independent of the RTS marks
    curReq = "R2";
    for (int i = 0; i <= 12; i++) begin fillLevel = 6'(i); step(); end
    fillLevel = 6'd7; step(); chk("irq below trigger", rxIrq, 1'b0);
    fillLevel = 6'd8; step(); chk("irq at trigger", rxIrq, 1'b1);
    fillLevel = 6'd0; step();

    // Hysteresis, valid order
    curReq = "R3";
    for (int i = 0; i <= 30; i++) begin fillLevel = 6'(i); step(); end
    fillLevel = 6'd5;  step();
    fillLevel = 6'd23; step(); chk("rts below high", rtsN, 1'b0);
    fillLevel = 6'd24; step(); chk("rts at high", rtsN, 1'b1);
    curReq = "R4";
    fillLevel = 6'd11; step(); chk("rts held above low", rtsN, 1'b1);
    fillLevel = 6'd10; step(); chk("rts resumes at low", rtsN, 1'b0);
    for (int i = 30; i >= 0; i--) begin fillLevel = 6'(i); step(); end

    // Reversed marks
    curReq = "R5";
    rtsHigh = 6'd10; rtsLow = 6'd20;
    fillLevel = 6'd10; step(); chk("reversed stop at high", rtsN, 1'b1);
    fillLevel = 6'd15; step(); chk("reversed held between marks", rtsN, 1'b1);
    fillLevel = 6'd9;  step(); chk("reversed resume below both", rtsN, 1'b0);
    for (int i = 0; i <= 25; i++) begin fillLevel = 6'(i); step(); end
    rtsHigh = 6'd24; rtsLow = 6'd10; fillLevel = 6'd0; step();

    // Software RTS
    curReq = "R6";
    autoRtsEn = 1'b0; fillLevel = 6'd30;
    swRts = 1'b1; step(); chk("sw assert ignores fill", rtsN, 1'b0);
    swRts = 1'b0; step(); chk("sw deassert", rtsN, 1'b1);
    swRts = 1'b1; step(); step();
    autoRtsEn = 1'b1; step(); chk("auto re-enabled above high", rtsN, 1'b1);
    fillLevel = 6'd0; step();

    // CTS synchronizer latency
    curReq = "R7";
    txIdle = 1'b1; autoCtsEn = 1'b1; ctsN = 1'b0; repeat (4) step();
    ctsN = 1'b1;
    step(); chk("permit after 1 edge", txPermit, 1'b1);
    step(); chk("permit after 2 edges", txPermit, 1'b1);
    step(); chk("permit after 3 edges", txPermit, 1'b0);
    ctsN = 1'b0; repeat (3) step(); chk("permit resumes", txPermit, 1'b1);

    // Boundary gating
    curReq = "R8";
    txIdle = 1'b0; ctsN = 1'b1; repeat (6) step();
    chk("permit held mid-character", txPermit, 1'b1);
    txIdle = 1'b1; step(); chk("permit at boundary", txPermit, 1'b0);
    for (int i = 0; i < 20; i++) begin
      txIdle = i[0]; ctsN = i[2]; step();
    end

    // Automatic CTS off
    curReq = "R9";
    txIdle = 1'b1; ctsN = 1'b1; repeat (3) step();
    autoCtsEn = 1'b0; step(); chk("permit ignores cts", txPermit, 1'b1);
    repeat (3) step();

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL %s watchdog: got timeout expected completion", curReq);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule